// File: doc/BRIEF.md
# In-Order Hazard Scoreboard

This block tracks the destination registers of instructions that have issued but not yet reached writeback in an in-order pipeline. The register-fetch stage presents the two source register indices of its instruction and gets back a stall flag. The flag is high while either source names a register that still has a write pending. Issue pushes one entry per instruction through the insert port. Writeback pops one entry per retired instruction, oldest first, through the single remove port. This includes instructions that were poisoned on a wrong path: their entries are dropped only when they reach writeback, never early.

Entries live in a circular queue whose depth is a parameter. Set it to at least the number of stages between register fetch and writeback. An instruction with no destination still takes a slot, holding an entry that matches nothing, so the queue order stays aligned with the pipeline. A compile-time parameter chooses the ordering within a cycle. In plain ordering, a removal becomes visible to the search one cycle later. In remove-first ordering, the entry leaving this cycle is already hidden from this cycle's search, and its slot can take this cycle's insert. This matches the way a pipelined FIFO dequeues before it enqueues.

Top module: `hazard_scoreboard`

## Requirements
- R1: `stall` is high when `src_a` or `src_b` equals the register index of any pending entry that carries a destination, and is low otherwise (in particular when the queue is empty).
- R2: Register index 0 never causes a stall: a source of 0 matches nothing, and an insert with destination 0 records an entry that matches nothing.
- R3: An insert with `ins_has_dst` low still occupies one slot, so DEPTH inserts of any kind fill the queue (DEPTH = 4 by default).
- R4: When the queue holds DEPTH entries, `ins_ready` is low (except as in R7), and an `ins_valid` pulse while `ins_ready` is low changes nothing.
- R5: Each `rm_valid` pulse removes exactly the oldest entry; younger entries stay visible to the search. Removal on an empty queue is illegal.
- R6: With plain ordering (ORDER = 0), an entry removed in a cycle still causes a stall in that same cycle and stops doing so from the next cycle on.
- R7: With remove-first ordering (ORDER = 1), the entry being removed in a cycle is hidden from that cycle's search, and `ins_ready` is high in any cycle with `rm_valid`, even when the queue is full.
- R8: An entry inserted in a cycle is not seen by that same cycle's search. It causes stalls from the next cycle on.
- R9: An active-low asynchronous reset empties the queue: `ins_ready` goes high and `stall` goes low at once.
- R10: Sustained insert-and-remove traffic across more than DEPTH entries keeps strict arrival order as the head and tail indices wrap around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_valid | input | 1 | Issue stage pushes an entry this cycle |
| ins_has_dst | input | 1 | The issuing instruction writes a register |
| ins_dst | input | REG_W | Destination register index of the issuing instruction |
| ins_ready | output | 1 | A slot is available for an insert this cycle |
| src_a | input | REG_W | First source register index to search |
| src_b | input | REG_W | Second source register index to search |
| stall | output | 1 | A source has a pending write (RAW hazard) |
| rm_valid | input | 1 | Writeback retires the oldest entry this cycle |

## Verification
The bench drives the same stimulus into both ordering variants side by side. It checks the cycles where they must differ: a consumer that reads the register being retired, and an insert offered to a full queue during a removal. A design that ignores the ordering choice stalls one cycle too long, or stalls one cycle too short in plain mode, or loses an issue slot. Other cases cover destination-less inserts and register 0. An implementation that skips the slot for a destination-less insert, or that records register 0, would show `ins_ready` too early or stalls on register 0 that should not happen. Further cases target a removal whose matching entry is not the oldest, and long traffic that wraps the pointers. A queue that pops the wrong slot, or whose pointers wrap badly, reports a retired register as still pending or drops a live one.

// File: rtl/sb_pkg.sv
package sb_pkg;

  // Ordering of a same-cycle remove against the hazard search.
  typedef enum logic {
    SB_ORDER_PLAIN        = 1'b0,
    SB_ORDER_REMOVE_FIRST = 1'b1
  } sb_order_e;

endpackage

// File: rtl/sb_fifo_ctrl.sv
module sb_fifo_ctrl #(
  parameter int               DEPTH = 4,
  parameter sb_pkg::sb_order_e ORDER = sb_pkg::SB_ORDER_PLAIN,
  localparam int              PTR_W = $clog2(DEPTH),
  localparam int              CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ins_valid,
  input  logic             rm_valid,
  output logic             wr_en,
  output logic             rd_en,
  output logic             ins_ready,
  output logic [PTR_W-1:0] head,
  output logic [PTR_W-1:0] tail,
  output logic [CNT_W-1:0] occupancy
);

  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam bit REMOVE_FIRST = (ORDER == sb_pkg::SB_ORDER_REMOVE_FIRST);

  logic [PTR_W-1:0] head_q, head_d;
  logic [PTR_W-1:0] tail_q, tail_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             is_full, is_empty;

  assign is_full   = (cnt_q == FULL_CNT);
  assign is_empty  = (cnt_q == '0);
  assign rd_en     = rm_valid && !is_empty;
  assign ins_ready = !is_full || (REMOVE_FIRST && rd_en);
  assign wr_en     = ins_valid && ins_ready;

  always_comb begin
    head_d = head_q;
    tail_d = tail_q;
    cnt_d  = cnt_q;
    if (rd_en) begin
      head_d = (head_q == LAST_PTR) ? '0 : head_q + 1'b1;
    end
    if (wr_en) begin
      tail_d = (tail_q == LAST_PTR) ? '0 : tail_q + 1'b1;
    end
    case ({wr_en, rd_en})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (rd_en) head_q <= head_d;
      if (wr_en) tail_q <= tail_d;
      if (rd_en || wr_en) cnt_q <= cnt_d;
    end
  end

  assign head      = head_q;
  assign tail      = tail_q;
  assign occupancy = cnt_q;

endmodule

// File: rtl/sb_entry_store.sv
module sb_entry_store #(
  parameter int  DEPTH = 4,
  parameter int  REG_W = 5,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic                       rd_en,
  input  logic [PTR_W-1:0]           head,
  input  logic [PTR_W-1:0]           tail,
  input  logic                       wr_live,
  input  logic [REG_W-1:0]           wr_idx,
  output logic [DEPTH-1:0]           slot_live,
  output logic [DEPTH-1:0][REG_W-1:0] slot_idx
);

  logic [DEPTH-1:0]            live_q, live_d;
  logic [DEPTH-1:0][REG_W-1:0] idx_q;

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
    logic hit_wr, hit_rd;
    assign hit_wr = wr_en && (tail == PTR_W'(gi));
    assign hit_rd = rd_en && (head == PTR_W'(gi));

    always_comb begin
      live_d[gi] = live_q[gi];
      if (hit_rd) live_d[gi] = 1'b0;
      if (hit_wr) live_d[gi] = wr_live;  // insert wins when slots coincide
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        live_q[gi] <= 1'b0;
      end else if (hit_wr || hit_rd) begin
        live_q[gi] <= live_d[gi];
      end
    end

    always_ff @(posedge clk) begin
      if (hit_wr) idx_q[gi] <= wr_idx;
    end
  end

  assign slot_live = live_q;
  assign slot_idx  = idx_q;

endmodule

// File: rtl/sb_hazard_match.sv
module sb_hazard_match #(
  parameter int               DEPTH = 4,
  parameter int               REG_W = 5,
  parameter sb_pkg::sb_order_e ORDER = sb_pkg::SB_ORDER_PLAIN,
  localparam int              PTR_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0]            slot_live,
  input  logic [DEPTH-1:0][REG_W-1:0] slot_idx,
  input  logic                        rd_en,
  input  logic [PTR_W-1:0]            head,
  input  logic [REG_W-1:0]            src_a,
  input  logic [REG_W-1:0]            src_b,
  output logic                        stall
);

  logic [DEPTH-1:0] hit;
  logic             a_nonzero, b_nonzero;

  assign a_nonzero = (src_a != '0);
  assign b_nonzero = (src_b != '0);

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_cmp
    logic visible;
    if (ORDER == sb_pkg::SB_ORDER_REMOVE_FIRST) begin : g_mask
      assign visible = slot_live[gi] && !(rd_en && (head == PTR_W'(gi)));
    end else begin : g_plain
      assign visible = slot_live[gi];
    end
    assign hit[gi] = visible &&
                     ((a_nonzero && (slot_idx[gi] == src_a)) ||
                      (b_nonzero && (slot_idx[gi] == src_b)));
  end

  assign stall = |hit;

endmodule

// File: rtl/hazard_scoreboard.sv
module hazard_scoreboard #(
  parameter int               DEPTH = 4,
  parameter int               REG_W = 5,
  parameter sb_pkg::sb_order_e ORDER = sb_pkg::SB_ORDER_PLAIN,
  localparam int              PTR_W = $clog2(DEPTH),
  localparam int              CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ins_valid,
  input  logic             ins_has_dst,
  input  logic [REG_W-1:0] ins_dst,
  output logic             ins_ready,
  input  logic [REG_W-1:0] src_a,
  input  logic [REG_W-1:0] src_b,
  output logic             stall,
  input  logic             rm_valid
);

  logic                        wr_en, rd_en, wr_live;
  logic [PTR_W-1:0]            head, tail;
  logic [CNT_W-1:0]            occupancy;
  logic [DEPTH-1:0]            slot_live;
  logic [DEPTH-1:0][REG_W-1:0] slot_idx;

  // Register 0 is never a real producer: store it as a dead entry.
  assign wr_live = ins_has_dst && (ins_dst != '0);

  sb_fifo_ctrl #(.DEPTH(DEPTH), .ORDER(ORDER)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .ins_valid (ins_valid),
    .rm_valid  (rm_valid),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .ins_ready (ins_ready),
    .head      (head),
    .tail      (tail),
    .occupancy (occupancy)
  );

  sb_entry_store #(.DEPTH(DEPTH), .REG_W(REG_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .head      (head),
    .tail      (tail),
    .wr_live   (wr_live),
    .wr_idx    (ins_dst),
    .slot_live (slot_live),
    .slot_idx  (slot_idx)
  );

  sb_hazard_match #(.DEPTH(DEPTH), .REG_W(REG_W), .ORDER(ORDER)) u_match (
    .slot_live (slot_live),
    .slot_idx  (slot_idx),
    .rd_en     (rd_en),
    .head      (head),
    .src_a     (src_a),
    .src_b     (src_b),
    .stall     (stall)
  );

endmodule

// File: rtl/hazard_scoreboard_chk.sv
module hazard_scoreboard_chk #(
  parameter int DEPTH        = 4,
  parameter int REG_W        = 5,
  parameter int CNT_W        = 3,
  parameter bit REMOVE_FIRST = 1'b0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ins_valid,
  input logic             ins_ready,
  input logic             rm_valid,
  input logic [REG_W-1:0] src_a,
  input logic [REG_W-1:0] src_b,
  input logic             stall,
  input logic [CNT_W-1:0] occupancy
);

  assert_occupancy_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> occupancy == $past(occupancy)
                          + CNT_W'($past(ins_valid && ins_ready))
                          - CNT_W'($past(rm_valid)));

  assert_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
    occupancy <= CNT_W'(DEPTH));

  assert_full_refuses_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (occupancy == CNT_W'(DEPTH) && !(REMOVE_FIRST && rm_valid)) |-> !ins_ready);

  assert_no_remove_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rm_valid |-> occupancy != '0);

  assert_zero_src_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (src_a == '0 && src_b == '0) |-> !stall);

  assert_empty_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (occupancy == '0) |-> !stall);

  assert_pipe_slot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (REMOVE_FIRST && rm_valid) |-> ins_ready);

endmodule

bind hazard_scoreboard hazard_scoreboard_chk #(
  .DEPTH        (DEPTH),
  .REG_W        (REG_W),
  .CNT_W        (CNT_W),
  .REMOVE_FIRST (ORDER == sb_pkg::SB_ORDER_REMOVE_FIRST)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ins_valid (ins_valid),
  .ins_ready (ins_ready),
  .rm_valid  (rm_valid),
  .src_a     (src_a),
  .src_b     (src_b),
  .stall     (stall),
  .occupancy (occupancy)
);

// File: tb/hazard_scoreboard_tb.sv
module hazard_scoreboard_tb;

  localparam int DEPTH = 4;
  localparam int REG_W = 5;

  logic clk;
  logic rst_n;
  logic ins_valid, ins_has_dst, rm_valid;
  logic [REG_W-1:0] ins_dst, src_a, src_b;
  logic rdy_pl, rdy_pp, stall_pl, stall_pp;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  hazard_scoreboard #(.DEPTH(DEPTH), .REG_W(REG_W), .ORDER(sb_pkg::SB_ORDER_PLAIN)) u_dut (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_has_dst(ins_has_dst),
    .ins_dst(ins_dst), .ins_ready(rdy_pl), .src_a(src_a), .src_b(src_b),
    .stall(stall_pl), .rm_valid(rm_valid)
  );

  hazard_scoreboard #(.DEPTH(DEPTH), .REG_W(REG_W), .ORDER(sb_pkg::SB_ORDER_REMOVE_FIRST)) u_dut_pipe (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_has_dst(ins_has_dst),
    .ins_dst(ins_dst), .ins_ready(rdy_pp), .src_a(src_a), .src_b(src_b),
    .stall(stall_pp), .rm_valid(rm_valid)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct packed {
    logic       iv;
    logic       hd;
    logic [4:0] dst;
    logic [4:0] sa;
    logic [4:0] sb;
    logic       rm;
    logic       st_pl;
    logic       st_pp;
    logic       rd_pl;
    logic       rd_pp;
  } vec_t;

  // iv hd dst sa sb rm | stall plain/pipe | ready plain/pipe
  localparam vec_t VEC [0:14] = '{
    '{1'b1,1'b1,5'd3, 5'd1,5'd2, 1'b0, 1'b0,1'b0, 1'b1,1'b1}, // 0 R1 empty, no stall
    '{1'b1,1'b1,5'd5, 5'd3,5'd0, 1'b0, 1'b1,1'b1, 1'b1,1'b1}, // 1 R1 r3 pending
    '{1'b1,1'b0,5'd7, 5'd7,5'd0, 1'b0, 1'b0,1'b0, 1'b1,1'b1}, // 2 R3 no-dst insert
    '{1'b1,1'b1,5'd0, 5'd0,5'd0, 1'b0, 1'b0,1'b0, 1'b1,1'b1}, // 3 R2 dst 0 insert
    '{1'b1,1'b1,5'd9, 5'd0,5'd0, 1'b0, 1'b0,1'b0, 1'b0,1'b0}, // 4 R3 R4 full
    '{1'b0,1'b0,5'd0, 5'd3,5'd1, 1'b1, 1'b1,1'b0, 1'b0,1'b1}, // 5 R6 R7 remove oldest
    '{1'b1,1'b1,5'd9, 5'd5,5'd5, 1'b0, 1'b1,1'b1, 1'b1,1'b1}, // 6 R4 r9 was dropped
    '{1'b0,1'b0,5'd0, 5'd9,5'd2, 1'b1, 1'b1,1'b1, 1'b0,1'b1}, // 7 R5 R7 young stays
    '{1'b0,1'b0,5'd0, 5'd5,5'd2, 1'b0, 1'b0,1'b0, 1'b1,1'b1}, // 8 R6 gone next cycle
    '{1'b0,1'b0,5'd0, 5'd2,5'd2, 1'b1, 1'b0,1'b0, 1'b1,1'b1}, // 9 R5 pop dead entry
    '{1'b0,1'b0,5'd0, 5'd9,5'd0, 1'b1, 1'b1,1'b1, 1'b1,1'b1}, // 10 R5 r9 not oldest
    '{1'b0,1'b0,5'd0, 5'd0,5'd9, 1'b1, 1'b1,1'b0, 1'b1,1'b1}, // 11 R6 R7 r9 retiring
    '{1'b1,1'b1,5'd4, 5'd4,5'd4, 1'b0, 1'b0,1'b0, 1'b1,1'b1}, // 12 R8 own insert unseen
    '{1'b1,1'b1,5'd4, 5'd4,5'd1, 1'b1, 1'b1,1'b0, 1'b1,1'b1}, // 13 R6 R7 swap r4
    '{1'b0,1'b0,5'd0, 5'd6,5'd4, 1'b1, 1'b1,1'b0, 1'b1,1'b1}  // 14 R6 R7 last r4
  };

  function automatic string tag_of(input int i);
    case (i)
      0, 1:          tag_of = "R1";
      2:             tag_of = "R3";
      3:             tag_of = "R2";
      4:             tag_of = "R4";
      5, 11, 13, 14: tag_of = "R6/R7";
      6:             tag_of = "R4";
      7, 9, 10:      tag_of = "R5";
      8:             tag_of = "R6";
      12:            tag_of = "R8";
      default:       tag_of = "R1";
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic drive(input logic iv, input logic hd, input logic [4:0] dst,
                       input logic [4:0] sa, input logic [4:0] sb, input logic rm);
    @(negedge clk);
    ins_valid   = iv;
    ins_has_dst = hd;
    ins_dst     = dst;
    src_a       = sa;
    src_b       = sb;
    rm_valid    = rm;
    #2;
  endtask

  initial begin
    rst_n = 1'b0;
    ins_valid = 1'b0; ins_has_dst = 1'b0; ins_dst = '0;
    src_a = '0; src_b = '0; rm_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;

    // R9: reset state
    drive(1'b0, 1'b0, 5'd0, 5'd3, 5'd7, 1'b0);
    chk("R9", "ready plain after reset", rdy_pl, 1'b1);
    chk("R9", "ready pipe after reset", rdy_pp, 1'b1);
    chk("R9", "stall plain after reset", stall_pl, 1'b0);
    chk("R9", "stall pipe after reset", stall_pp, 1'b0);

    // Vector table
    for (int i = 0; i < 15; i++) begin
      drive(VEC[i].iv, VEC[i].hd, VEC[i].dst, VEC[i].sa, VEC[i].sb, VEC[i].rm);
      chk(tag_of(i), $sformatf("vec %0d stall plain", i), stall_pl, VEC[i].st_pl);
      chk(tag_of(i), $sformatf("vec %0d stall pipe", i), stall_pp, VEC[i].st_pp);
      chk(tag_of(i), $sformatf("vec %0d ready plain", i), rdy_pl, VEC[i].rd_pl);
      chk(tag_of(i), $sformatf("vec %0d ready pipe", i), rdy_pp, VEC[i].rd_pp);
    end

    // R10: sustained flow wraps the pointers, queue holds one entry
    drive(1'b1, 1'b1, 5'd1, 5'd0, 5'd0, 1'b0);
    for (int k = 2; k < 12; k++) begin
      drive(1'b1, 1'b1, 5'(k), 5'(k - 1), 5'd0, 1'b1);
      chk("R10", $sformatf("wrap %0d stall plain", k), stall_pl, 1'b1);
      chk("R10", $sformatf("wrap %0d stall pipe", k), stall_pp, 1'b0);
    end
    drive(1'b0, 1'b0, 5'd0, 5'd11, 5'd0, 1'b1);
    chk("R10", "final retire stall plain", stall_pl, 1'b1);
    chk("R10", "final retire stall pipe", stall_pp, 1'b0);
    drive(1'b0, 1'b0, 5'd0, 5'd11, 5'd10, 1'b0);
    chk("R5", "drained stall plain", stall_pl, 1'b0);
    chk("R5", "drained stall pipe", stall_pp, 1'b0);

    // R9: reset while full
    for (int k = 2; k < 6; k++) drive(1'b1, 1'b1, 5'(k), 5'd0, 5'd0, 1'b0);
    drive(1'b0, 1'b0, 5'd0, 5'd2, 5'd0, 1'b0);
    chk("R4", "full ready plain", rdy_pl, 1'b0);
    chk("R1", "full stall plain", stall_pl, 1'b1);
    rst_n = 1'b0;
    #1;
    chk("R9", "mid reset ready plain", rdy_pl, 1'b1);
    chk("R9", "mid reset stall plain", stall_pl, 1'b0);
    chk("R9", "mid reset stall pipe", stall_pp, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    drive(1'b0, 1'b0, 5'd0, 5'd2, 5'd5, 1'b0);
    chk("R9", "after reset stall plain", stall_pl, 1'b0);
    chk("R9", "after reset ready pipe", rdy_pp, 1'b1);

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

endmodule